// File: doc/BRIEF.md
# Paged Address Translator with Kernel Pass-Through

This block sits between an 8-bit CPU with a 16-bit logical address bus and a physical memory system of up to 1 MB. The logical space is cut into sixteen 4 KB pages. Each page owns a mapping entry that supplies an 8-bit physical page number, a write-protect attribute and a no-execute attribute. The physical address is formed from that page number and the 12-bit offset within the page. Every clock edge ends one bus cycle. The address path is combinational from the current logical address and the registered mode. The bus has no back-pressure, so every port is a plain control or status pin.

The unit has two modes. In kernel mode (pass-through) the logical space maps one-to-one onto the lowest 64 KB and the attributes are ignored. In user mode the mapping entries apply. Reset leaves the unit in kernel mode. Whenever the CPU signals a vector fetch, the unit drops to kernel mode in that same cycle, so interrupt handlers always start in a known map. Kernel software programs the entries through a 256-byte register slot at logical `$E0xx`. It can switch user mode on or off at once, or arm a delayed switch so that a return-from-interrupt fetches its opcode in the kernel map and pulls its stack bytes in the user map.

Top module: `paged_mmu`

## Requirements
- R1: After reset the unit is in kernel mode: `map_active` is 0 and `phys_addr` equals `{4'h0, cpu_addr}`.
- R2: In kernel mode, a write to `$E000 + 2n` loads the data byte as the physical page number of page n (n = 0..15). A write to `$E000 + 2n + 1` loads page n's attributes from data bit 3 (write-protect) and bit 2 (no-execute). In user mode `phys_addr = {ppn[cpu_addr[15:12]], cpu_addr[11:0]}`.
- R3: In kernel mode, a write to `$E020` sets the user-mode flag to data bit 0 from the next cycle on. This write also cancels any pending delayed switch.
- R4: In kernel mode, a write of any value to `$E021` (cycle T) leaves cycles T+1 and T+2 in kernel mode. User mode starts in cycle T+3.
- R5: While `vec_pull` is high, the cycle is translated in kernel mode. The flag is cleared for the following cycles.
- R6: A `vec_pull` in any cycle between a trigger write and the cycle in which it would take effect cancels the pending switch.
- R7: In user mode, a write to a page with write-protect set reaches memory with `mem_we` low. In kernel mode `mem_we` always follows `cpu_we`.
- R8: `nx_hit` is high exactly when `cpu_sync` is high, the unit is in user mode, and the current page has no-execute set. The translated address is unaffected.
- R9: In user mode, writes to `$E000`–`$E0FF` leave the mapping entries, the flag and the trigger unchanged. They are passed to memory like any other write.
- R10: A `vec_pull` wins over a control write that sets the flag in the same cycle. It also wins over a delayed switch that would complete at the end of that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock; each rising edge ends a bus cycle |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_addr | input | 16 | Logical address of the current bus cycle |
| cpu_we | input | 1 | CPU write strobe for the current cycle |
| cpu_wdata | input | 8 | CPU write data |
| cpu_sync | input | 1 | High during an opcode-fetch cycle |
| vec_pull | input | 1 | High while the CPU reads an interrupt or reset vector |
| phys_addr | output | 20 | Translated physical address |
| mem_we | output | 1 | Write strobe to memory after protection gating |
| nx_hit | output | 1 | Opcode fetch from a no-execute page in user mode |
| map_active | output | 1 | High when the current cycle uses the user map |

## Verification
The vector pull and the mode switch can land on the same clock edge. This happens either through a control write that sets the flag or through the delayed trigger finishing its two-cycle countdown. The bench provokes both cases. It asserts `vec_pull` in the same cycle as a flag-setting control write, and it asserts `vec_pull` in cycle T+2 after a trigger write. In both cases it judges from the ports that the following cycles stay in the one-to-one map with `map_active` low. A pull one cycle earlier, in T+1, is also covered, to show that cancellation does not depend on where in the countdown the pull arrives.

// File: rtl/pmmu_pkg.sv
package pmmu_pkg;
  localparam int LA_W      = 16;
  localparam int PAGE_BITS = 4;
  localparam int PPN_W     = 8;
  localparam int OFF_W     = LA_W - PAGE_BITS;
  localparam int PAGES     = 1 << PAGE_BITS;
  localparam int PA_W      = PPN_W + OFF_W;
  localparam int SLOT_W    = 8;
  localparam logic [SLOT_W-1:0] SLOT_HI  = 8'hE0;
  localparam logic [7:0]        CTRL_OFF = 8'(2 * PAGES);
  localparam logic [7:0]        TRIG_OFF = 8'(2 * PAGES + 1);
  localparam int ATTR_WP_BIT = 3;
  localparam int ATTR_NX_BIT = 2;

  typedef struct packed {
    logic             wp;
    logic             nx;
    logic [PPN_W-1:0] ppn;
  } map_entry_t;
endpackage

// File: rtl/pmmu_regbus.sv
module pmmu_regbus
  import pmmu_pkg::*;
(
  input  logic [LA_W-1:0]      la,
  input  logic                 we,
  input  logic                 user_map,
  output logic                 map_wr,
  output logic                 map_wr_hi,
  output logic [PAGE_BITS-1:0] map_idx,
  output logic                 ctrl_wr,
  output logic                 trig_wr
);
  logic       slot_hit;
  logic       kern_wr;
  logic [7:0] off8;

  assign off8     = la[7:0];
  assign slot_hit = (la[LA_W-1:LA_W-SLOT_W] == SLOT_HI);
  assign kern_wr  = we & ~user_map & slot_hit;

  assign map_wr    = kern_wr & (off8 < CTRL_OFF);
  assign map_wr_hi = off8[0];
  assign map_idx   = off8[PAGE_BITS:1];
  assign ctrl_wr   = kern_wr & (off8 == CTRL_OFF);
  assign trig_wr   = kern_wr & (off8 == TRIG_OFF);
endmodule

// File: rtl/pmmu_page_table.sv
module pmmu_page_table
  import pmmu_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 wr,
  input  logic                 wr_hi,
  input  logic [PAGE_BITS-1:0] wr_idx,
  input  logic [7:0]           wdata,
  input  logic [PAGE_BITS-1:0] rd_idx,
  output map_entry_t           rd_entry
);
  map_entry_t ent_all [PAGES];

  for (genvar p = 0; p < PAGES; p++) begin : g_page
    map_entry_t ent_q;
    logic       sel;
    assign sel = wr & (wr_idx == PAGE_BITS'(p));
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        ent_q <= '0;
      end else if (sel) begin
        if (wr_hi) begin
          ent_q.wp <= wdata[ATTR_WP_BIT];
          ent_q.nx <= wdata[ATTR_NX_BIT];
        end else begin
          ent_q.ppn <= wdata[PPN_W-1:0];
        end
      end
    end
    assign ent_all[p] = ent_q;
  end

  assign rd_entry = ent_all[rd_idx];
endmodule

// File: rtl/pmmu_mode_ctrl.sv
module pmmu_mode_ctrl #(
  parameter int ENABLE_DELAY = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic vec_pull,
  input  logic ctrl_wr,
  input  logic ctrl_bit,
  input  logic trig_wr,
  output logic user_map
);
  localparam int CNT_W = $clog2(ENABLE_DELAY + 1);
  localparam logic [CNT_W-1:0] CNT_LOAD = CNT_W'(ENABLE_DELAY);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(1);

  logic             en_q;
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      en_q  <= 1'b0;
      cnt_q <= '0;
    end else if (vec_pull) begin
      en_q  <= 1'b0;
      cnt_q <= '0;
    end else if (ctrl_wr) begin
      en_q  <= ctrl_bit;
      cnt_q <= '0;
    end else if (trig_wr) begin
      cnt_q <= CNT_LOAD;
    end else if (cnt_q != '0) begin
      cnt_q <= cnt_q - CNT_LAST;
      if (cnt_q == CNT_LAST) en_q <= 1'b1;
    end
  end

  assign user_map = en_q & ~vec_pull;
endmodule

// File: rtl/pmmu_xlate.sv
module pmmu_xlate
  import pmmu_pkg::*;
(
  input  logic [LA_W-1:0]      la,
  input  logic                 we,
  input  logic                 sync,
  input  logic                 user_map,
  input  map_entry_t           entry,
  output logic [PAGE_BITS-1:0] page,
  output logic [PA_W-1:0]      pa,
  output logic                 mem_we,
  output logic                 nx_hit
);
  logic [OFF_W-1:0] off;

  assign page = la[LA_W-1:OFF_W];
  assign off  = la[OFF_W-1:0];

  always_comb begin
    if (user_map) pa = {entry.ppn, off};
    else          pa = {{(PPN_W-PAGE_BITS){1'b0}}, page, off};
  end

  assign mem_we = we & ~(user_map & entry.wp);
  assign nx_hit = sync & user_map & entry.nx;
endmodule

// File: rtl/paged_mmu.sv
module paged_mmu
  import pmmu_pkg::*;
#(
  parameter int ENABLE_DELAY = 2
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [15:0] cpu_addr,
  input  logic        cpu_we,
  input  logic [7:0]  cpu_wdata,
  input  logic        cpu_sync,
  input  logic        vec_pull,
  output logic [19:0] phys_addr,
  output logic        mem_we,
  output logic        nx_hit,
  output logic        map_active
);
  logic                 user_map;
  logic                 map_wr, map_wr_hi, ctrl_wr, trig_wr;
  logic [PAGE_BITS-1:0] map_idx, page;
  map_entry_t           entry;

  pmmu_regbus u_bus (
    .la(cpu_addr), .we(cpu_we), .user_map(user_map),
    .map_wr(map_wr), .map_wr_hi(map_wr_hi), .map_idx(map_idx),
    .ctrl_wr(ctrl_wr), .trig_wr(trig_wr)
  );

  pmmu_page_table u_tbl (
    .clk(clk), .rst_n(rst_n), .wr(map_wr), .wr_hi(map_wr_hi),
    .wr_idx(map_idx), .wdata(cpu_wdata), .rd_idx(page), .rd_entry(entry)
  );

  pmmu_mode_ctrl #(.ENABLE_DELAY(ENABLE_DELAY)) u_mode (
    .clk(clk), .rst_n(rst_n), .vec_pull(vec_pull), .ctrl_wr(ctrl_wr),
    .ctrl_bit(cpu_wdata[0]), .trig_wr(trig_wr), .user_map(user_map)
  );

  pmmu_xlate u_xl (
    .la(cpu_addr), .we(cpu_we), .sync(cpu_sync), .user_map(user_map),
    .entry(entry), .page(page), .pa(phys_addr), .mem_we(mem_we),
    .nx_hit(nx_hit)
  );

  assign map_active = user_map;
endmodule

// File: rtl/paged_mmu_chk.sv
module paged_mmu_chk
  import pmmu_pkg::*;
(
  input logic        clk,
  input logic        rst_n,
  input logic [15:0] cpu_addr,
  input logic        cpu_we,
  input logic [7:0]  cpu_wdata,
  input logic        cpu_sync,
  input logic        vec_pull,
  input logic [19:0] phys_addr,
  input logic        mem_we,
  input logic        nx_hit,
  input logic        map_active
);
  logic trig_hit, ctrl_on;
  assign trig_hit = cpu_we && !map_active && !vec_pull &&
                    cpu_addr == {SLOT_HI, TRIG_OFF};
  assign ctrl_on  = cpu_we && !map_active && !vec_pull && cpu_wdata[0] &&
                    cpu_addr == {SLOT_HI, CTRL_OFF};

  // R5
  a_r5_vec_passthru: assert property (@(posedge clk) disable iff (!rst_n)
    vec_pull |-> (!map_active && phys_addr == {4'h0, cpu_addr}));
  // R5, R10
  a_r5_vec_clears: assert property (@(posedge clk) disable iff (!rst_n)
    vec_pull |=> !map_active);
  // R7
  a_r7_kernel_we: assert property (@(posedge clk) disable iff (!rst_n)
    !map_active |-> (mem_we == cpu_we));
  a_r7_no_spurious_we: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> cpu_we);
  // R8
  a_r8_nx_qualified: assert property (@(posedge clk) disable iff (!rst_n)
    nx_hit |-> (cpu_sync && map_active));
  // R4
  a_r4_trig_waits: assert property (@(posedge clk) disable iff (!rst_n)
    trig_hit |=> !map_active);
  // R3
  a_r3_ctrl_sets: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_on |=> (map_active || vec_pull));
endmodule

bind paged_mmu paged_mmu_chk u_chk (
  .clk(clk), .rst_n(rst_n), .cpu_addr(cpu_addr), .cpu_we(cpu_we),
  .cpu_wdata(cpu_wdata), .cpu_sync(cpu_sync), .vec_pull(vec_pull),
  .phys_addr(phys_addr), .mem_we(mem_we), .nx_hit(nx_hit),
  .map_active(map_active)
);

// File: tb/sim_paged_mmu.sv
`timescale 1ns/1ps
module sim_paged_mmu;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [15:0] cpu_addr;
  logic        cpu_we;
  logic [7:0]  cpu_wdata;
  logic        cpu_sync;
  logic        vec_pull;
  logic [19:0] phys_addr;
  logic        mem_we, nx_hit, map_active;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  paged_mmu u0 (
    .clk(clk), .rst_n(rst_n), .cpu_addr(cpu_addr), .cpu_we(cpu_we),
    .cpu_wdata(cpu_wdata), .cpu_sync(cpu_sync), .vec_pull(vec_pull),
    .phys_addr(phys_addr), .mem_we(mem_we), .nx_hit(nx_hit),
    .map_active(map_active)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // drive one bus cycle; outputs are valid 1 ns later, well before the edge
  task automatic bus(input logic [15:0] a, input logic we, input logic [7:0] d,
                     input logic vp, input logic sy);
    cpu_addr = a; cpu_we = we; cpu_wdata = d; vec_pull = vp; cpu_sync = sy;
    #1;
  endtask

  task automatic next();
    @(negedge clk);
  endtask

  task automatic idle(input logic [15:0] a);
    bus(a, 1'b0, 8'h00, 1'b0, 1'b0);
  endtask

  task automatic wr(input logic [15:0] a, input logic [7:0] d);
    bus(a, 1'b1, d, 1'b0, 1'b0); next();
  endtask

  task automatic leave_user();
    bus(16'hFFFE, 1'b0, 8'h00, 1'b1, 1'b0); next();
  endtask

  task automatic t_reset();
    idle(16'h1234);
    check("R1 map_active", {31'b0, map_active}, 0);
    check("R1 phys", {12'b0, phys_addr}, 32'h01234);
    bus(16'hD0F0, 1'b1, 8'h55, 1'b0, 1'b0);
    check("R1 mem_we", {31'b0, mem_we}, 1);
    next();
  endtask

  task automatic t_program();
    wr(16'hE002, 8'hA5); wr(16'hE003, 8'h00);
    wr(16'hE004, 8'h3C); wr(16'hE005, 8'h08);
    wr(16'hE006, 8'h77); wr(16'hE007, 8'h04);
    idle(16'h1234);
    check("R2 kernel ignores table", {12'b0, phys_addr}, 32'h01234);
    next();
    wr(16'hE020, 8'h01);
    idle(16'h1234);
    check("R3 flag set", {31'b0, map_active}, 1);
    check("R2 translate page1", {12'b0, phys_addr}, 32'hA5234);
    next();
  endtask

  task automatic t_protect();
    bus(16'h2010, 1'b1, 8'h9A, 1'b0, 1'b0);
    check("R7 wp blocks", {31'b0, mem_we}, 0);
    check("R2 translate page2", {12'b0, phys_addr}, 32'h3C010);
    next();
    bus(16'h1010, 1'b1, 8'h9A, 1'b0, 1'b0);
    check("R7 unprotected write", {31'b0, mem_we}, 1);
    next();
    bus(16'h3456, 1'b0, 8'h00, 1'b0, 1'b1);
    check("R8 nx flagged", {31'b0, nx_hit}, 1);
    check("R8 nx not blocking", {12'b0, phys_addr}, 32'h77456);
    next();
    bus(16'h3456, 1'b0, 8'h00, 1'b0, 1'b0);
    check("R8 no sync", {31'b0, nx_hit}, 0);
    next();
    bus(16'h1000, 1'b0, 8'h00, 1'b0, 1'b1);
    check("R8 page without nx", {31'b0, nx_hit}, 0);
    next();
  endtask

  task automatic t_user_ignores();
    bus(16'hE002, 1'b1, 8'h11, 1'b0, 1'b0);
    check("R9 write passed on", {31'b0, mem_we}, 1);
    next();
    wr(16'hE020, 8'h00);
    wr(16'hE021, 8'h00);
    idle(16'h1234);
    check("R9 still user", {31'b0, map_active}, 1);
    check("R9 entry unchanged", {12'b0, phys_addr}, 32'hA5234);
    next();
  endtask

  task automatic t_vector();
    bus(16'hFFFE, 1'b0, 8'h00, 1'b1, 1'b0);
    check("R5 vector passthru", {12'b0, phys_addr}, 32'h0FFFE);
    check("R5 vector mode", {31'b0, map_active}, 0);
    next();
    idle(16'h1234);
    check("R5 stays kernel", {12'b0, phys_addr}, 32'h01234);
    next();
    bus(16'h2000, 1'b1, 8'h01, 1'b0, 1'b1);
    check("R7 kernel ignores wp", {31'b0, mem_we}, 1);
    next();
    bus(16'h3000, 1'b0, 8'h00, 1'b0, 1'b1);
    check("R8 kernel ignores nx", {31'b0, nx_hit}, 0);
    next();
  endtask

  task automatic t_trigger();
    bus(16'hE021, 1'b1, 8'h00, 1'b0, 1'b0);
    check("R4 cycle T", {31'b0, map_active}, 0);
    next();
    bus(16'h1234, 1'b0, 8'h00, 1'b0, 1'b1);
    check("R4 T+1 kernel", {12'b0, phys_addr}, 32'h01234);
    next();
    idle(16'h1234);
    check("R4 T+2 kernel", {12'b0, phys_addr}, 32'h01234);
    next();
    idle(16'h1234);
    check("R4 T+3 user", {12'b0, phys_addr}, 32'hA5234);
    check("R4 T+3 flag", {31'b0, map_active}, 1);
    next();
    leave_user();
  endtask

  task automatic t_cancel();
    wr(16'hE021, 8'h00);
    bus(16'hFFFA, 1'b0, 8'h00, 1'b1, 1'b0); next();
    for (int i = 0; i < 3; i++) begin
      idle(16'h1234);
      check("R6 cancelled", {12'b0, phys_addr}, 32'h01234);
      next();
    end
    wr(16'hE021, 8'h00);
    wr(16'hE020, 8'h00);
    for (int i = 0; i < 3; i++) begin
      idle(16'h1234);
      check("R3 ctrl cancels trigger", {31'b0, map_active}, 0);
      next();
    end
  endtask

  task automatic t_collide();
    wr(16'hE021, 8'h00);
    idle(16'h1234); next();
    bus(16'hFFFC, 1'b0, 8'h00, 1'b1, 1'b0);
    check("R10 pull at T+2", {12'b0, phys_addr}, 32'h0FFFC);
    next();
    idle(16'h1234);
    check("R10 trigger lost", {31'b0, map_active}, 0);
    next();
    bus(16'hE020, 1'b1, 8'h01, 1'b1, 1'b0); next();
    idle(16'h1234);
    check("R10 ctrl lost", {31'b0, map_active}, 0);
    check("R10 ctrl lost phys", {12'b0, phys_addr}, 32'h01234);
    next();
  endtask

  task automatic summary();
    if (!done) begin
      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  endtask

  initial begin
    rst_n = 1'b0;
    idle(16'h0000);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_program();
    t_protect();
    t_user_ignores();
    t_vector();
    t_trigger();
    t_cancel();
    t_collide();
    summary();
  end

  initial begin
    repeat (5000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=running expected=finished");
    summary();
  end
endmodule